// File: doc/BRIEF.md
# GPIO Interrupt Hold/Through Capture

This block conditions interrupt events from sixteen general-purpose input pins. Each pin is brought into the clock domain by a two-stage synchronizer. A rising edge on the synchronized level is that pin's interrupt event. A per-pin mode bit chooses what happens to the event. In through mode the event shows in the status view for one cycle only. In hold mode the event is latched and stays pending until software clears it.

Software reaches the block through a small synchronous register port with three registers: mode, enable and status. The single interrupt request output is active when any pin has a status bit set and its enable bit set. A held event is recorded even while its pin is disabled, so setting the enable bit later raises the request with no new pin activity. The highest channel is wired by the system to a modem carrier-detect line, and it is handled the same way as every other channel.

Top module: `gpio_irq_hold`

## Requirements
- R1: After reset the mode, enable and status registers all read 0 and `irq_o` is low.
- R2: With the pin's mode bit at 0 (through), a rising pin edge sets that status bit for exactly one cycle. The bit is visible at the first falling clock edge after the second rising clock edge that follows the pin change, and it is not latched.
- R3: With the pin's mode bit at 1 (hold), a rising pin edge sets that status bit and the bit stays at 1 after the pin returns low.
- R4: Writing the status register (address 2) clears each held bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R5: A write to the enable register (address 1) leaves the mode register unchanged, and a write to the mode register (address 0) leaves the enable register unchanged.
- R6: When a clear of a held bit and a new event on the same pin fall in the same cycle, the bit stays set.
- R7: `irq_o` is the OR over all pins of (status bit AND enable bit). A held event captured while the pin is disabled raises `irq_o` as soon as its enable bit is written to 1.
- R8: The channels are independent. An event on pin n changes only status bit n, for every n from 0 to 15, and this includes the carrier-detect channel 15.
- R9: Writing a pin's mode bit to 0 discards that pin's held event, and the event does not return when the mode bit is set to 1 again.
- R10: Address 3 reads as 0 and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | 16 | Raw pin levels; bit 15 is the carrier-detect line |
| addr_i | input | 2 | Register select: 0 mode, 1 enable, 2 status, 3 unused |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same clock edge as a new capture on the same pin. The synchronizer delays the edge by two cycles, so the bench raises the pin on a falling clock edge. It waits exactly two rising edges and then puts the write-1-to-clear on the bus so that it lands on the edge where the capture happens. The pending-while-disabled case is reached by capturing with the enable bit at 0, dropping the pin, waiting, and only then writing the enable bit. This is repeated on every channel.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_ENABLE = 2'd1,
    REG_STATUS = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NCH    = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] edge_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [NCH-1:0] stg_q [STAGES];
  logic [NCH-1:0] stg_d [STAGES];
  logic [NCH-1:0] prev_q;

  always_comb begin
    stg_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[LAST];
  end

  assign edge_o = stg_q[LAST] & ~prev_q;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_o) |=> ((edge_o & $past(edge_o)) == '0)); // R2
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic status_o
);
  logic held_q;
  logic held_d;

  always_comb begin
    held_d = hold_i & (edge_i | (held_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign status_o = hold_i ? held_q : edge_i;

  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && hold_i && !clr_i) |=> held_q); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && clr_i && !edge_i) |=> !held_q); // R4
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && edge_i) |=> held_q); // R6
  AST_THROUGH_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> !held_q); // R9
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NCH-1:0]    wdata_i,
  input  logic [NCH-1:0]    status_i,
  output logic [NCH-1:0]    mode_o,
  output logic [NCH-1:0]    en_o,
  output logic [NCH-1:0]    clr_o,
  output logic [NCH-1:0]    rdata_o
);
  reg_sel_e       sel;
  logic           mode_we;
  logic           en_we;
  logic [NCH-1:0] mode_q;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] mode_d;
  logic [NCH-1:0] en_d;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    mode_we = we_i && (sel == REG_MODE);
    en_we   = we_i && (sel == REG_ENABLE);
    mode_d  = mode_we ? wdata_i : mode_q;
    en_d    = en_we ? wdata_i : en_q;
    clr_o   = (we_i && (sel == REG_STATUS)) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    case (sel)
      REG_MODE:   rdata_o = mode_q;
      REG_ENABLE: rdata_o = en_q;
      REG_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel != REG_MODE) |=> $stable(mode_q)); // R5
  AST_ENABLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel != REG_ENABLE) |=> $stable(en_q)); // R5
endmodule

// File: rtl/gpio_irq_hold.sv
module gpio_irq_hold
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NCH         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NCH-1:0]    wdata_i,
  output logic [NCH-1:0]    rdata_o,
  output logic              irq_o
);
  logic [1:0]     rst_sync_q;
  logic           rst_n;
  logic [NCH-1:0] edge_w;
  logic [NCH-1:0] mode_w;
  logic [NCH-1:0] en_w;
  logic [NCH-1:0] clr_w;
  logic [NCH-1:0] status_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  gpio_irq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_i),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .edge_o (edge_w)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    gpio_irq_chan u_chan (
      .clk      (clk_i),
      .rst_n    (rst_n),
      .hold_i   (mode_w[n]),
      .edge_i   (edge_w[n]),
      .clr_i    (clr_w[n]),
      .status_o (status_w[n])
    );
  end

  gpio_irq_regs #(.NCH(NCH)) u_regs (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .status_i (status_w),
    .mode_o   (mode_w),
    .en_o     (en_w),
    .clr_o    (clr_w),
    .rdata_o  (rdata_o)
  );

  assign irq_o = |(status_w & en_w);

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_w == '0) |-> !irq_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n |-> (!irq_o && mode_w == '0 && en_w == '0)); // R1
endmodule

// File: tb/sim_gpio_irq_hold.sv
module sim_gpio_irq_hold;
  logic        clk;
  logic        rst_n;
  logic [15:0] pin;
  logic [1:0]  addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  int          checks;
  int          errors;

  gpio_irq_hold u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .pin_i   (pin),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
    addr = 2'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise pin bits at a falling edge, return at the falling edge where the edge pulse is live
  task automatic rise(input logic [15:0] m);
    @(negedge clk);
    pin = pin | m;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    checks = 0; errors = 0;
    pin = '0; addr = 2'd2; we = 1'b0; wdata = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 / R10: reset values and the unused address
    rd(2'd0, v); chk("R1 mode", v, 16'h0000);
    rd(2'd1, v); chk("R1 enable", v, 16'h0000);
    rd(2'd2, v); chk("R1 status", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    rd(2'd3, v); chk("R10 read", v, 16'h0000);

    // R5 / R10: register independence
    wr(2'd0, 16'hA5A5);
    wr(2'd1, 16'h0F0F);
    rd(2'd0, v); chk("R5 mode after enable write", v, 16'hA5A5);
    wr(2'd0, 16'h1234);
    rd(2'd1, v); chk("R5 enable after mode write", v, 16'h0F0F);
    wr(2'd3, 16'hFFFF);
    rd(2'd0, v); chk("R10 mode", v, 16'h1234);
    rd(2'd1, v); chk("R10 enable", v, 16'h0F0F);
    rd(2'd3, v); chk("R10 read after write", v, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);

    // R8: sweep every channel in both modes
    for (int n = 0; n < 16; n++) begin
      logic [15:0] b;
      b = 16'h1 << n;
      // through mode
      wr(2'd1, b);
      rise(b);
      rd(2'd2, v); chk("R2 R8 through pulse", v, b);
      chk("R7 through irq", {15'b0, irq}, 16'h0001);
      @(negedge clk);
      rd(2'd2, v); chk("R2 through gone", v, 16'h0000);
      chk("R7 irq gone", {15'b0, irq}, 16'h0000);
      pin = '0;
      idle(4);
      // hold mode, interrupt disabled
      wr(2'd1, 16'h0000);
      wr(2'd0, b);
      rise(b);
      @(negedge clk);
      rd(2'd2, v); chk("R3 R8 captured", v, b);
      chk("R7 masked", {15'b0, irq}, 16'h0000);
      pin = '0;
      idle(4);
      rd(2'd2, v); chk("R3 held after pin low", v, b);
      wr(2'd1, b);
      chk("R7 pending fires", {15'b0, irq}, 16'h0001);
      wr(2'd2, ~b);
      rd(2'd2, v); chk("R4 zero-write keeps", v, b);
      wr(2'd2, b);
      rd(2'd2, v); chk("R4 cleared", v, 16'h0000);
      chk("R4 irq cleared", {15'b0, irq}, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h0000);
    end

    // R6: clear lands on the same edge as a new capture
    wr(2'd0, 16'h0008);
    rise(16'h0008);
    pin = '0;
    idle(4);
    rd(2'd2, v); chk("R6 first event", v, 16'h0008);
    rise(16'h0008);
    addr = 2'd2; wdata = 16'h0008; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(2'd2, v); chk("R6 capture wins", v, 16'h0008);
    pin = '0;
    idle(4);
    wr(2'd2, 16'h0008);
    rd(2'd2, v); chk("R6 later clear", v, 16'h0000);

    // R9: leaving hold mode discards the event
    wr(2'd0, 16'h0020);
    rise(16'h0020);
    pin = '0;
    idle(4);
    rd(2'd2, v); chk("R9 captured", v, 16'h0020);
    wr(2'd0, 16'h0000);
    rd(2'd2, v); chk("R9 dropped", v, 16'h0000);
    wr(2'd0, 16'h0020);
    rd(2'd2, v); chk("R9 not restored", v, 16'h0000);

    // R7 / R4: all pins at once
    wr(2'd0, 16'hFFFF);
    rise(16'hFFFF);
    pin = '0;
    idle(4);
    rd(2'd2, v); chk("R3 all held", v, 16'hFFFF);
    chk("R7 none enabled", {15'b0, irq}, 16'h0000);
    wr(2'd1, 16'h8001);
    chk("R7 some enabled", {15'b0, irq}, 16'h0001);
    wr(2'd2, 16'h7FFE);
    rd(2'd2, v); chk("R4 partial clear", v, 16'h8001);
    chk("R7 still pending", {15'b0, irq}, 16'h0001);
    wr(2'd2, 16'h8001);
    rd(2'd2, v); chk("R4 full clear", v, 16'h0000);
    chk("R7 idle", {15'b0, irq}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule